// File: doc/BRIEF.md
# Locked Watchdog Timer with Reset Pulse

This block is a watchdog counter for a small microcontroller. It comes out of reset disabled. Software turns it on by writing a two-byte key to a restart register, and services it by writing the same key again before the period runs out. No register write can stop it once it runs; only the system reset returns it to the disabled state. A 3-bit timeout selector scales the period in powers of two. The watchdog tick is either the core clock or the core clock divided by two, picked by a mode input.

The count keeps going while the processor is idle. It freezes during power-down and stays frozen until a wake indication from an interrupt source arrives, then continues from the held value. When the count reaches its limit the block drives an active-low reset output for a fixed number of clock cycles. While that pulse is driven the watchdog's own state is held cleared, so it comes out of the pulse disabled.

Top module: `lockwd_top`

## Requirements
- R1: After `rst_ni` the watchdog is disabled, `wdt_rst_no` is high, and no pulse appears however long the block is left without writes.
- R2: A write of 0x1E followed by a write of 0xE1 to the restart register (address `RST_ADDR`, default 0) enables the watchdog; its count starts from zero at the clock edge that takes the 0xE1 write.
- R3: 0xE1 counts only when the previous write to the restart register was 0xE1's partner 0x1E; any other value written to the restart register in between cancels the key, while writes to other addresses leave the key progress untouched.
- R4: Once enabled, no write of any value to any address disables the watchdog; only `rst_ni` does.
- R5: With the timeout field `sel` (bits [2:0] of the register at `SEL_ADDR`, default 1) the pulse starts `BASE_MULT * 2^(BASE_SHIFT + sel)` watchdog ticks after the edge that completed the last key.
- R6: With `ckdiv2_i` low the watchdog ticks on every clock; with it high it ticks on every second clock, doubling the timeout measured in clocks.
- R7: Completing the key while enabled restarts the count from zero, so the next pulse comes a full period after that service.
- R8: A new `sel` value is used only from the next key completion on; the period already running keeps its length.
- R9: `idle_i` has no effect on counting.
- R10: While `pdown_i` is high the count holds; after `pdown_i` falls it stays held until `wake_i` is sampled high, and counting resumes on the following clock from the held value.
- R11: The reset pulse holds `wdt_rst_no` low for exactly `PULSE_LEN` clock cycles.
- R12: During the pulse writes are ignored and all watchdog state is cleared; after it the watchdog is disabled and `sel` reads as 0 in the timeout it produces.
- R13: `rst_ni` asserted during power-down clears and disables the watchdog; a later key starts a fresh full period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Core clock |
| rst_ni | input | 1 | Asynchronous active-low system reset |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | AW | Register write address |
| wr_data_i | input | DW | Register write data |
| ckdiv2_i | input | 1 | Tick mode: 0 every clock, 1 every second clock |
| idle_i | input | 1 | Processor idle status |
| pdown_i | input | 1 | Power-down status |
| wake_i | input | 1 | Interrupt wake indication ending power-down |
| wdt_rst_no | output | 1 | Active-low reset pulse on expiry |

## Verification
The bench builds the block with `BASE_SHIFT` = 2 and `PULSE_LEN` = 10, which turns the periods into 24 to 3072 ticks. That brings every one of the eight timeout settings in both tick modes into a single run, each measured to the exact clock of expiry, together with the full pulse width. The short periods also leave room for the key-order cases, service, power-down freeze and resume, and writes landing inside the pulse.

// File: rtl/lockwd_pkg.sv
package lockwd_pkg;

  // Power state seen by the watchdog, decoded from the status inputs.
  typedef enum logic [1:0] {
    PW_RUN  = 2'd0,
    PW_IDLE = 2'd1,
    PW_DOWN = 2'd2
  } pwr_e;

  function automatic pwr_e pwr_decode(input logic idle, input logic pdown);
    if (pdown)     return PW_DOWN;
    else if (idle) return PW_IDLE;
    else           return PW_RUN;
  endfunction

endpackage

// File: rtl/lockwd_key.sv
// Key sequence detector on the restart register and timeout field storage.
module lockwd_key #(
  parameter int            DW       = 8,
  parameter int            AW       = 2,
  parameter int            SEL_W    = 3,
  parameter logic [DW-1:0] KEY_A    = 8'h1E,
  parameter logic [DW-1:0] KEY_B    = 8'hE1,
  parameter logic [AW-1:0] RST_ADDR = 2'd0,
  parameter logic [AW-1:0] SEL_ADDR = 2'd1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             srst_i,
  input  logic             wr_en_i,
  input  logic [AW-1:0]    wr_addr_i,
  input  logic [DW-1:0]    wr_data_i,
  output logic             unlock_o,
  output logic [SEL_W-1:0] sel_o
);

  logic             armed_q, armed_d, armed_ce;
  logic [SEL_W-1:0] sel_q, sel_d;
  logic             sel_ce;
  logic             rst_wr, sel_wr;

  always_comb begin
    rst_wr   = wr_en_i && (wr_addr_i == RST_ADDR);
    sel_wr   = wr_en_i && (wr_addr_i == SEL_ADDR);
    armed_ce = srst_i || rst_wr;
    sel_ce   = srst_i || sel_wr;
    armed_d  = armed_q;
    sel_d    = sel_q;
    if (srst_i) begin
      armed_d = 1'b0;
      sel_d   = '0;
    end else begin
      if (rst_wr) armed_d = (wr_data_i == KEY_A);
      if (sel_wr) sel_d   = wr_data_i[SEL_W-1:0];
    end
    unlock_o = !srst_i && rst_wr && armed_q && (wr_data_i == KEY_B);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       armed_q <= 1'b0;
    else if (armed_ce) armed_q <= armed_d;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     sel_q <= '0;
    else if (sel_ce) sel_q <= sel_d;
  end

  assign sel_o = sel_q;

endmodule

// File: rtl/lockwd_pwr.sv
// Power-state tracking: the count may advance in run and idle, and is held
// from power-down entry until a wake indication is seen.
module lockwd_pwr
  import lockwd_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic srst_i,
  input  logic idle_i,
  input  logic pdown_i,
  input  logic wake_i,
  output logic run_o
);

  pwr_e pstate;
  logic hold_q, hold_d, hold_ce;

  always_comb begin
    pstate  = pwr_decode(idle_i, pdown_i);
    hold_d  = hold_q;
    if (srst_i)                 hold_d = 1'b0;
    else if (pstate == PW_DOWN) hold_d = 1'b1;
    else if (wake_i)            hold_d = 1'b0;
    hold_ce = (hold_d != hold_q);
    run_o   = (pstate != PW_DOWN) && !hold_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      hold_q <= 1'b0;
    else if (hold_ce) hold_q <= hold_d;
  end

endmodule

// File: rtl/lockwd_count.sv
// Enable latch, tick divider and period counter with expiry detection.
module lockwd_count #(
  parameter int BASE_MULT  = 6,
  parameter int BASE_SHIFT = 14,
  parameter int SEL_W      = 3,
  parameter int CNT_W      = 24
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             srst_i,
  input  logic             unlock_i,
  input  logic [SEL_W-1:0] sel_i,
  input  logic             div2_i,
  input  logic             run_i,
  output logic             en_o,
  output logic             expire_o
);

  logic             en_q, en_d;
  logic             ph_q, ph_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [SEL_W-1:0] sact_q, sact_d;
  logic [CNT_W-1:0] last;
  logic             tick, adv, ce;

  always_comb begin
    last     = (CNT_W'(BASE_MULT) << (BASE_SHIFT + int'(sact_q))) - CNT_W'(1);
    tick     = div2_i ? ph_q : 1'b1;
    adv      = en_q && run_i && tick;
    expire_o = adv && (cnt_q == last);
  end

  always_comb begin
    en_d   = en_q;
    ph_d   = ph_q;
    cnt_d  = cnt_q;
    sact_d = sact_q;
    if (srst_i) begin
      en_d   = 1'b0;
      ph_d   = 1'b0;
      cnt_d  = '0;
      sact_d = '0;
    end else if (unlock_i) begin
      en_d   = 1'b1;
      ph_d   = 1'b0;
      cnt_d  = '0;
      sact_d = sel_i;
    end else if (expire_o) begin
      en_d   = 1'b0;
      ph_d   = 1'b0;
      cnt_d  = '0;
    end else begin
      if (en_q && run_i) ph_d  = !ph_q;
      if (adv)           cnt_d = cnt_q + CNT_W'(1);
    end
    ce = srst_i || unlock_i || (en_q && run_i);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q   <= 1'b0;
      ph_q   <= 1'b0;
      cnt_q  <= '0;
      sact_q <= '0;
    end else if (ce) begin
      en_q   <= en_d;
      ph_q   <= ph_d;
      cnt_q  <= cnt_d;
      sact_q <= sact_d;
    end
  end

  assign en_o = en_q;

endmodule

// File: rtl/lockwd_pulse.sv
// Fixed-length active-low reset pulse generator.
module lockwd_pulse #(
  parameter int PULSE_LEN = 96
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic fire_i,
  output logic active_o,
  output logic rst_no
);

  localparam int PW = $clog2(PULSE_LEN + 1);

  logic [PW-1:0] left_q, left_d;
  logic          ce;

  always_comb begin
    active_o = (left_q != '0);
    left_d   = left_q;
    if (fire_i)        left_d = PW'(PULSE_LEN);
    else if (active_o) left_d = left_q - PW'(1);
    ce       = fire_i || active_o;
    rst_no   = !active_o;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)  left_q <= '0;
    else if (ce)  left_q <= left_d;
  end

endmodule

// File: rtl/lockwd_top.sv
module lockwd_top #(
  parameter int            DW         = 8,
  parameter int            AW         = 2,
  parameter int            SEL_W      = 3,
  parameter int            BASE_MULT  = 6,
  parameter int            BASE_SHIFT = 14,
  parameter int            PULSE_LEN  = 96,
  parameter logic [DW-1:0] KEY_A      = 8'h1E,
  parameter logic [DW-1:0] KEY_B      = 8'hE1,
  parameter logic [AW-1:0] RST_ADDR   = 2'd0,
  parameter logic [AW-1:0] SEL_ADDR   = 2'd1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_en_i,
  input  logic [AW-1:0] wr_addr_i,
  input  logic [DW-1:0] wr_data_i,
  input  logic          ckdiv2_i,
  input  logic          idle_i,
  input  logic          pdown_i,
  input  logic          wake_i,
  output logic          wdt_rst_no
);

  localparam int CNT_W = $clog2(BASE_MULT) + BASE_SHIFT + (1 << SEL_W) - 1;

  // Asynchronous assertion, synchronous release.
  logic [1:0] rsync_q;
  logic       rst_n_s;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rsync_q <= '0;
    else         rsync_q <= {rsync_q[0], 1'b1};
  end
  assign rst_n_s = rsync_q[1];

  logic             pls_act;
  logic             unlock;
  logic [SEL_W-1:0] sel;
  logic             run;
  logic             en;
  logic             expire;

  lockwd_key #(
    .DW(DW), .AW(AW), .SEL_W(SEL_W),
    .KEY_A(KEY_A), .KEY_B(KEY_B),
    .RST_ADDR(RST_ADDR), .SEL_ADDR(SEL_ADDR)
  ) u_key (
    .clk_i     (clk_i),
    .rst_ni    (rst_n_s),
    .srst_i    (pls_act),
    .wr_en_i   (wr_en_i),
    .wr_addr_i (wr_addr_i),
    .wr_data_i (wr_data_i),
    .unlock_o  (unlock),
    .sel_o     (sel)
  );

  lockwd_pwr u_pwr (
    .clk_i   (clk_i),
    .rst_ni  (rst_n_s),
    .srst_i  (pls_act),
    .idle_i  (idle_i),
    .pdown_i (pdown_i),
    .wake_i  (wake_i),
    .run_o   (run)
  );

  lockwd_count #(
    .BASE_MULT(BASE_MULT), .BASE_SHIFT(BASE_SHIFT),
    .SEL_W(SEL_W), .CNT_W(CNT_W)
  ) u_count (
    .clk_i    (clk_i),
    .rst_ni   (rst_n_s),
    .srst_i   (pls_act),
    .unlock_i (unlock),
    .sel_i    (sel),
    .div2_i   (ckdiv2_i),
    .run_i    (run),
    .en_o     (en),
    .expire_o (expire)
  );

  lockwd_pulse #(
    .PULSE_LEN(PULSE_LEN)
  ) u_pulse (
    .clk_i    (clk_i),
    .rst_ni   (rst_n_s),
    .fire_i   (expire),
    .active_o (pls_act),
    .rst_no   (wdt_rst_no)
  );

endmodule

// File: rtl/lockwd_chk.sv
module lockwd_chk #(
  parameter int            DW        = 8,
  parameter int            AW        = 2,
  parameter int            CNT_W     = 24,
  parameter int            PULSE_LEN = 96,
  parameter logic [DW-1:0] KEY_B     = 8'hE1,
  parameter logic [AW-1:0] RST_ADDR  = 2'd0
) (
  input logic             clk,
  input logic             rst_n,
  input logic             wr_en,
  input logic [AW-1:0]    wr_addr,
  input logic [DW-1:0]    wr_data,
  input logic             pdown,
  input logic             en,
  input logic             expire,
  input logic [CNT_W-1:0] cnt,
  input logic             wdt_rst_n
);

  // Counts consecutive low samples of the reset output.
  logic [15:0] low_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         low_n <= '0;
    else if (wdt_rst_n) low_n <= '0;
    else                low_n <= low_n + 16'd1;
  end

  p_off_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !en |-> !expire);

  p_key_done_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(en) |-> $past(wr_en && (wr_addr == RST_ADDR) && (wr_data == KEY_B)));

  p_no_disable_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(en) |-> !wdt_rst_n);

  p_fire_r5: assert property (@(posedge clk) disable iff (!rst_n)
    expire |=> !wdt_rst_n);

  p_freeze_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (pdown && en && !wr_en) |=> $stable(cnt));

  p_pulse_len_r11: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wdt_rst_n) |-> (low_n == 16'(PULSE_LEN)));

  p_pulse_cap_r11: assert property (@(posedge clk) disable iff (!rst_n)
    low_n <= 16'(PULSE_LEN));

  p_held_r12: assert property (@(posedge clk) disable iff (!rst_n)
    !wdt_rst_n |-> !en);

endmodule

bind lockwd_top lockwd_chk #(
  .DW(DW), .AW(AW), .CNT_W(CNT_W), .PULSE_LEN(PULSE_LEN),
  .KEY_B(KEY_B), .RST_ADDR(RST_ADDR)
) u_chk (
  .clk       (clk_i),
  .rst_n     (rst_n_s),
  .wr_en     (wr_en_i),
  .wr_addr   (wr_addr_i),
  .wr_data   (wr_data_i),
  .pdown     (pdown_i),
  .en        (en),
  .expire    (expire),
  .cnt       (u_count.cnt_q),
  .wdt_rst_n (wdt_rst_no)
);

// File: tb/test_lockwd_top.sv
`timescale 1ns/1ps
module test_lockwd_top;

  localparam int PLEN  = 10;
  localparam int BASE  = 6 * 4;   // BASE_MULT * 2^BASE_SHIFT with BASE_SHIFT = 2

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       we = 1'b0;
  logic [1:0] addr = '0;
  logic [7:0] data = '0;
  logic       div2 = 1'b0;
  logic       idle = 1'b0;
  logic       pdown = 1'b0;
  logic       wake = 1'b0;
  logic       wrst_n;

  int cyc = 0;
  int total = 0;
  int bad = 0;
  int t0 = 0;
  int t1 = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  lockwd_top #(.BASE_SHIFT(2), .PULSE_LEN(PLEN)) i_lockwd_top (
    .clk_i      (clk),
    .rst_ni     (rst_n),
    .wr_en_i    (we),
    .wr_addr_i  (addr),
    .wr_data_i  (data),
    .ckdiv2_i   (div2),
    .idle_i     (idle),
    .pdown_i    (pdown),
    .wake_i     (wake),
    .wdt_rst_no (wrst_n)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    pdown = 1'b0; wake = 1'b0; idle = 1'b0; we = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  // Called at a negedge; returns at the negedge after the sampling edge.
  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    we = 1'b1; addr = a; data = d;
    @(posedge clk);
    @(negedge clk);
    we = 1'b0;
  endtask

  task automatic key(output int t);
    wr(2'd0, 8'h1E);
    wr(2'd0, 8'hE1);
    t = cyc;
  endtask

  task automatic wait_to(input int c);
    while (cyc < c) @(negedge clk);
  endtask

  task automatic quiet(input int n, input string req);
    int lows = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (!wrst_n) lows++;
    end
    check(lows == 0, req, lows, 0);
  endtask

  // Expect the pulse to begin exactly len clocks after edge ts, then measure it.
  task automatic expect_fall(input int ts, input int len, input string req);
    int n = 0;
    wait_to(ts + len - 1);
    check(wrst_n == 1'b1, {req, " high before expiry"}, int'(wrst_n), 1);
    @(negedge clk);
    check(wrst_n == 1'b0, {req, " low at expiry"}, int'(wrst_n), 0);
    while (!wrst_n && n < PLEN + 5) begin
      n++;
      @(negedge clk);
    end
    check(n == PLEN, "R11 pulse width", n, PLEN);
  endtask

  initial begin
    wait (cyc > 150000);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog expired actual=%0d expected=<150000", cyc);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    // R1: disabled after reset
    do_reset();
    check(wrst_n == 1'b1, "R1 output after reset", int'(wrst_n), 1);
    quiet(300, "R1 no pulse while disabled");

    // R2 R5 R6 R9: every timeout setting in both tick modes
    for (int d = 0; d < 2; d++) begin
      for (int s = 0; s < 8; s++) begin
        do_reset();
        div2 = d[0];
        idle = s[0];
        wr(2'd1, 8'(s));
        key(t0);
        expect_fall(t0, (BASE << s) * (d + 1),
                    $sformatf("R2 R5 R6 sel=%0d div2=%0d", s, d));
        if (s == 0) quiet(80, "R12 disabled after pulse");
      end
    end
    div2 = 1'b0;
    idle = 1'b0;

    // R3: broken key does not enable
    do_reset();
    wr(2'd0, 8'h1E); wr(2'd0, 8'h00); wr(2'd0, 8'hE1);
    wr(2'd0, 8'hE1);
    quiet(100, "R3 broken or lone key");
    // R3: write to another address between keys keeps progress
    wr(2'd0, 8'h1E); wr(2'd1, 8'h00); wr(2'd0, 8'hE1);
    t0 = cyc;
    expect_fall(t0, BASE, "R3 other address between keys");
    // R3: repeated first byte re-arms
    do_reset();
    wr(2'd0, 8'h1E); wr(2'd0, 8'h1E); wr(2'd0, 8'hE1);
    t0 = cyc;
    expect_fall(t0, BASE, "R3 doubled first byte");

    // R4: no write stops it
    do_reset();
    key(t0);
    wr(2'd0, 8'h00); wr(2'd0, 8'hFF); wr(2'd0, 8'h1E); wr(2'd0, 8'h00);
    wr(2'd2, 8'h00); wr(2'd3, 8'hFF);
    expect_fall(t0, BASE, "R4 writes cannot disable");
    // R4: reset does stop it
    do_reset();
    key(t0);
    repeat (5) @(negedge clk);
    do_reset();
    quiet(100, "R4 reset disables");

    // R7: service restarts the period
    do_reset();
    key(t0);
    wait_to(t0 + 15);
    key(t1);
    expect_fall(t1, BASE, "R7 service restarts count");

    // R8: new timeout applies at next key only
    do_reset();
    key(t0);
    wr(2'd1, 8'd2);
    expect_fall(t0, BASE, "R8 running period unchanged");
    wr(2'd1, 8'd2);
    key(t1);
    wr(2'd1, 8'd0);
    expect_fall(t1, BASE << 2, "R8 new period after key");

    // R9: toggling idle during count
    do_reset();
    key(t0);
    for (int i = 0; i < 12; i++) begin
      idle = ~idle;
      @(negedge clk);
    end
    idle = 1'b0;
    expect_fall(t0, BASE, "R9 idle ignored");

    // R10: freeze across power-down, resume after wake (41 frozen edges)
    do_reset();
    key(t0);
    repeat (5) @(negedge clk);
    pdown = 1'b1;
    repeat (30) @(negedge clk);
    pdown = 1'b0;
    repeat (10) @(negedge clk);
    wake = 1'b1;
    @(negedge clk);
    wake = 1'b0;
    expect_fall(t0, BASE + 41, "R10 power-down hold and resume");

    // R12: writes during the pulse are ignored, state cleared
    do_reset();
    wr(2'd1, 8'd1);
    key(t0);
    wait_to(t0 + 2 * BASE);
    check(wrst_n == 1'b0, "R12 pulse started", int'(wrst_n), 0);
    wr(2'd0, 8'h1E); wr(2'd0, 8'hE1);
    check(wrst_n == 1'b0, "R12 still in pulse", int'(wrst_n), 0);
    repeat (PLEN) @(negedge clk);
    quiet(100, "R12 key during pulse ignored");
    key(t1);
    expect_fall(t1, BASE, "R12 timeout field cleared");

    // R13: reset during power-down
    do_reset();
    key(t0);
    pdown = 1'b1;
    repeat (10) @(negedge clk);
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    pdown = 1'b0;
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    quiet(100, "R13 disabled after reset in power-down");
    key(t1);
    expect_fall(t1, BASE, "R13 fresh period");

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule